// File: doc/BRIEF.md
# MDIO Idle-Level PHY Presence Monitor

This block senses whether a PHY is attached to a station-management bus by watching the resting level of the bidirectional data line. An attached PHY normally holds the line high through its pull-up. With nothing attached, the line rests low. The monitor resynchronises the raw line level into the local clock domain. While the management frame engine reports that it is idle, the monitor copies that level into a presence status bit.

While a management transaction runs, the line carries frame traffic, so the status bit is held at its last idle value. When the engine goes idle again, the monitor waits one guard cycle and then resumes tracking. Every change of the status bit, in either direction, sets a sticky change flag. Software clears the flag with a write-one strobe. An enable input gates the flag onto an interrupt request.

Top module: `mdio_presence_mon`

## Requirements
- R1: The line level passes through a two-stage synchroniser. A level change applied before clock edge 1 is not visible on the status bit after edge 2, and is visible after edge 3 (provided tracking is enabled).
- R2: While tracking, a high line level drives the status bit to 1 and a low line level drives it to 0.
- R3: At any clock edge where the busy input is 1, the status bit keeps its value, whatever the line does.
- R4: At the first clock edge after busy returns to 0, the status bit still holds. Tracking resumes from the second edge onward.
- R5: Any change of the status bit, rising or falling, sets the change flag at the same clock edge.
- R6: The change flag stays set until a clock edge where the clear strobe is 1 and the status bit does not change. At that edge it clears.
- R7: When the clear strobe and a status change fall on the same edge, the change flag remains set.
- R8: While reset is active and after it is released, the status bit is 0 and the change flag is 0.
- R9: The interrupt request equals the change flag ANDed with the interrupt enable input, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Raw level of the management data line |
| mgmt_busy_i | input | 1 | High while the frame engine runs a transaction |
| chg_clr_i | input | 1 | Write-one strobe that clears the change flag |
| irq_en_i | input | 1 | Interrupt enable |
| phy_present_o | output | 1 | Held idle-level status bit |
| chg_flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives the line through the following patterns:
- A rising step and a falling step while the engine is idle. These check the three-edge latency and show that both directions set the flag.
- Several toggles with busy held high. These separate a correct freeze from one that leaks frame traffic onto the status bit.
- A level that differs from the held value when busy drops, sampled edge by edge. This tells the guard cycle apart from an immediate resume.
- A clear strobe issued alone and a clear strobe coincident with a status change. Together these separate plain clearing from the set-over-clear priority.
- Toggling the enable while the flag is set, to show the gating of the interrupt request.

// File: rtl/mdio_det_pkg.sv
package mdio_det_pkg;

    // Width of the post-busy guard counter; bounds the guard length.
    localparam int unsigned GAP_CNT_W = 4;

    typedef struct packed {
        logic [GAP_CNT_W-1:0] gap;
        logic                 level;
    } trk_state_t;

    typedef struct packed {
        logic flag;
    } flg_state_t;

endpackage

// File: rtl/mdio_level_sync.sv
module mdio_level_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/mdio_idle_tracker.sv
module mdio_idle_tracker
    import mdio_det_pkg::*;
#(
    parameter int unsigned RESUME_GAP = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    input  logic busy_i,
    output logic level_o,
    output logic change_o
);
    localparam logic [GAP_CNT_W-1:0] GAP_LOAD = GAP_CNT_W'(RESUME_GAP);

    trk_state_t st_d, st_q;
    logic       track_en;

    always_comb begin
        st_d     = st_q;
        track_en = !busy_i && (st_q.gap == '0);
        change_o = 1'b0;
        if (busy_i) begin
            st_d.gap = GAP_LOAD;
        end else if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end
        if (track_en) begin
            st_d.level = level_i;
            change_o   = (level_i != st_q.level);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.level;
endmodule

// File: rtl/mdio_change_flag.sv
module mdio_change_flag
    import mdio_det_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/mdio_presence_mon.sv
module mdio_presence_mon #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RESUME_GAP  = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mdio_i,
    input  logic mgmt_busy_i,
    input  logic chg_clr_i,
    input  logic irq_en_i,
    output logic phy_present_o,
    output logic chg_flag_o,
    output logic irq_o
);
    logic line_sync;
    logic level_change;

    mdio_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (mdio_i),
        .sync_o  (line_sync)
    );

    mdio_idle_tracker #(.RESUME_GAP(RESUME_GAP)) u_track (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .level_i  (line_sync),
        .busy_i   (mgmt_busy_i),
        .level_o  (phy_present_o),
        .change_o (level_change)
    );

    mdio_change_flag u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (level_change),
        .clr_i  (chg_clr_i),
        .flag_o (chg_flag_o)
    );

    assign irq_o = chg_flag_o & irq_en_i;
endmodule

// File: rtl/mdio_presence_mon_chk.sv
module mdio_presence_mon_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic mgmt_busy_i,
    input logic chg_clr_i,
    input logic irq_en_i,
    input logic phy_present_o,
    input logic chg_flag_o,
    input logic irq_o
);
    // R3: a busy edge never moves the status bit
    p_busy_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mgmt_busy_i |=> $stable(phy_present_o));

    // R4: guard edge right after busy drops
    p_resume_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mgmt_busy_i && $past(mgmt_busy_i)) |=> $stable(phy_present_o));

    // R5: a status change leaves the flag set
    p_change_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(phy_present_o) |-> chg_flag_o);

    // R6: a set flag with no clear stays set
    p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chg_flag_o && !chg_clr_i) |=> chg_flag_o);

    // R6 / R7: a clear only wins when no change happens at that edge
    p_clear_rule_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chg_clr_i |=> (!chg_flag_o || !$stable(phy_present_o)));

    // R8: outputs are low while reset is held
    always_comb begin
        if (!rst_ni) begin
            p_reset_low_r8: assert final (!phy_present_o && !chg_flag_o);
        end
    end

    // R9: request tracks flag and enable
    p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (chg_flag_o && irq_en_i));
endmodule

bind mdio_presence_mon mdio_presence_mon_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mgmt_busy_i   (mgmt_busy_i),
    .chg_clr_i     (chg_clr_i),
    .irq_en_i      (irq_en_i),
    .phy_present_o (phy_present_o),
    .chg_flag_o    (chg_flag_o),
    .irq_o         (irq_o)
);

// File: tb/mdio_presence_mon_tb_top.sv
module mdio_presence_mon_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdio = 1'b0;
    logic busy = 1'b0;
    logic clr = 1'b0;
    logic en = 1'b0;
    logic present, flag, irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mdio_presence_mon dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .mdio_i        (mdio),
        .mgmt_busy_i   (busy),
        .chg_clr_i     (clr),
        .irq_en_i      (en),
        .phy_present_o (present),
        .chg_flag_o    (flag),
        .irq_o         (irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        clr = 1'b1; tick(1); clr = 1'b0;
    endtask

    task automatic t_reset();
        mdio = 1'b1;
        tick(3);
        chk("R8 status in reset", present, 1'b0);
        chk("R8 flag in reset", flag, 1'b0);
        mdio = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk("R8 status after reset", present, 1'b0);
        chk("R8 flag after reset", flag, 1'b0);
    endtask

    task automatic t_rise_latency();
        mdio = 1'b1;
        tick(2);
        chk("R1 no change after two edges", present, 1'b0);
        tick(1);
        chk("R1 R2 high after three edges", present, 1'b1);
        chk("R5 rising sets flag", flag, 1'b1);
    endtask

    task automatic t_clear();
        clear_flag();
        chk("R6 clear alone", flag, 1'b0);
        tick(4);
        chk("R6 stays clear", flag, 1'b0);
        chk("R2 high held", present, 1'b1);
    endtask

    task automatic t_fall();
        mdio = 1'b0;
        tick(3);
        chk("R2 low tracked", present, 1'b0);
        chk("R5 falling sets flag", flag, 1'b1);
        tick(3);
        chk("R6 flag sticky", flag, 1'b1);
        clear_flag();
        chk("R6 clear after fall", flag, 1'b0);
    endtask

    task automatic t_busy_freeze();
        busy = 1'b1;
        mdio = 1'b1;
        tick(6);
        chk("R3 held under busy", present, 1'b0);
        mdio = 1'b0; tick(3);
        mdio = 1'b1; tick(1);
        mdio = 1'b0; tick(1);
        mdio = 1'b1; tick(5);
        chk("R3 held after toggles", present, 1'b0);
        chk("R3 no flag under busy", flag, 1'b0);
    endtask

    task automatic t_resume();
        busy = 1'b0;
        tick(1);
        chk("R4 guard edge holds", present, 1'b0);
        chk("R4 no flag on guard", flag, 1'b0);
        tick(1);
        chk("R4 tracking resumed", present, 1'b1);
        chk("R5 flag on resume", flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_priority();
        busy = 1'b1;
        mdio = 1'b0;
        tick(4);
        busy = 1'b0;
        tick(1);
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
        chk("R7 status changed", present, 1'b0);
        chk("R7 set beats clear", flag, 1'b1);
        clear_flag();
        chk("R6 clear after priority", flag, 1'b0);
    endtask

    task automatic t_irq();
        en = 1'b0;
        mdio = 1'b1;
        tick(3);
        chk("R9 flag set", flag, 1'b1);
        chk("R9 masked", irq, 1'b0);
        en = 1'b1;
        #1;
        chk("R9 enabled", irq, 1'b1);
        tick(1);
        clear_flag();
        chk("R9 cleared", irq, 1'b0);
    endtask

    initial begin
        t_reset();
        t_rise_latency();
        t_clear();
        t_fall();
        t_busy_freeze();
        t_resume();
        t_priority();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule